// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block turns one loaded parameter set into a stream of array descriptors for a transfer engine. A transfer is three-dimensional. An array is a run of A-count bytes. A frame is a group of arrays. A block is C-count frames. For every array the sequencer presents a source address, a destination address and the byte length on a request port, one array per clock. Reading the parameter set from memory, the bus transfers themselves and chaining to further parameter sets are not part of this block.

The load pulse captures the parameter set and arms the block. Synchronization events then pace the walk. In array-synchronized mode one event releases a single array. In frame-synchronized mode one event releases all the arrays of one frame on consecutive clocks. Each side, source and destination, has its own signed 16-bit stride between arrays and its own signed 16-bit stride between frames. Either side can be set to constant-address (FIFO) mode, in which its address never moves. A 3-bit access-width code is carried to the output for that case.

The controller has three states:
- `ST_IDLE`: not loaded, or the block is finished.
- `ST_ARMED`: waiting for an event.
- `ST_ISSUE`: one array is presented on each clock.

The transitions are:
- `IDLE->ARMED` on load.
- `ARMED->ISSUE` on an event, or on an event held from earlier.
- `ISSUE->ARMED` when the current unit (one array, or one frame) ends.
- `ISSUE->IDLE` when the final array of the block is issued.
- Any state goes to `ARMED` on load. Load has priority over every other transition.

Top module: `dma3d_addr_seq`

## Requirements
- R1: After reset, and while no parameter set is loaded, `req_valid_o` and `done_o` are low and sync events produce no request.
- R2: With `ab_mode_i` = 0 (array-synchronized), an event sampled at a clock edge while armed makes exactly one request visible in the following cycle, and `req_valid_o` is low in the cycle after it.
- R3: With `ab_mode_i` = 1 (frame-synchronized), an event releases one whole frame: B-count requests on consecutive cycles.
- R4: `req_len_o` equals the A-count, which is taken from bits 15:0 of `cnt_i`; the B-count is taken from bits 31:16 of `cnt_i`; the C-count comes from `ccnt_i`.
- R5: Within a frame, each non-constant address advances by its signed array stride. The destination stride is in bits 31:16 of `aidx_i` and the source stride is in bits 15:0.
- R6: In array-synchronized mode, the first array of a new frame starts at the start of the previous frame's last array plus the signed frame stride. The destination frame stride is in bits 31:16 of `fidx_i` and the source frame stride is in bits 15:0.
- R7: In frame-synchronized mode, each new frame starts at the previous frame's start plus the frame stride.
- R8: In array-synchronized mode, the first frame has B-count arrays and every later frame has `rld_i` arrays; in frame-synchronized mode every frame has B-count arrays.
- R9: A side with its constant flag set (`src_fifo_i`, `dst_fifo_i`) keeps its loaded address for the whole block.
- R10: `fifo_width_o` shows the width code captured at the last load.
- R11: `done_o` is high for exactly one cycle, together with the last request of the block; after that, no request appears until the next load, whatever events arrive.
- R12: An event arriving while a unit is being issued is held and served when that unit ends. At most one event is held; further events during the same unit are dropped.
- R13: A load during a block abandons it, clears any held event, and restarts from the new parameter set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture the parameter set and arm |
| ab_mode_i | input | 1 | 1 = one frame per event, 0 = one array per event |
| src_fifo_i | input | 1 | Source address held constant |
| dst_fifo_i | input | 1 | Destination address held constant |
| fifo_width_i | input | 3 | Access-width code for constant mode |
| src_i | input | 32 | Source start address |
| dst_i | input | 32 | Destination start address |
| cnt_i | input | 32 | B-count in 31:16, A-count in 15:0 |
| ccnt_i | input | 16 | Frames per block |
| aidx_i | input | 32 | Array strides: destination 31:16, source 15:0 |
| fidx_i | input | 32 | Frame strides: destination 31:16, source 15:0 |
| rld_i | input | 16 | Arrays per frame after the first (array-synchronized mode) |
| sync_i | input | 1 | Synchronization event |
| req_valid_o | output | 1 | An array descriptor is presented this cycle |
| req_src_o | output | 32 | Source address of the array |
| req_dst_o | output | 32 | Destination address of the array |
| req_len_o | output | 16 | Array length in bytes |
| fifo_width_o | output | 3 | Captured width code |
| done_o | output | 1 | Last array of the block is presented |

## Verification
The walk is tried in both sync modes with random counts, random signed strides (including negative values) and a reload count that differs from the B-count. This separates the two frame-transition rules and the reload rule, because each of them yields a different address list. Directed runs cover three further cases. One holds one side constant while the other side moves. One bursts events during a frame, which tells a held event apart from a lost event or a double-served one. One reloads partway through a block, which shows that no stale counter, held event or stride survives the reload. Events after completion confirm that the finished state is sticky until the next load.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ISSUE = 2'd2
    } seq_state_e;

    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/dma3d_ctrl.sv
module dma3d_ctrl
    import dma3d_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       sync_i,
    input  logic       unit_end_i,
    input  logic       blk_end_i,
    output logic       issue_o
);

    seq_state_e state_q, state_d;
    logic       held_q, held_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // next state and held-event logic
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            ST_IDLE: begin
                held_d = 1'b0;
            end
            ST_ARMED: begin
                if (sync_i || held_q) begin
                    state_d = ST_ISSUE;
                    held_d  = sync_i && held_q;
                end
            end
            ST_ISSUE: begin
                held_d = held_q || sync_i;
                if (blk_end_i) begin
                    state_d = ST_IDLE;
                    held_d  = 1'b0;
                end else if (unit_end_i) begin
                    state_d = ST_ARMED;
                end
            end
            default: begin
                state_d = ST_IDLE;
                held_d  = 1'b0;
            end
        endcase
        if (load_i) begin
            state_d = ST_ARMED;
            held_d  = 1'b0;
        end
    end

    // outputs
    always_comb begin
        issue_o = (state_q == ST_ISSUE);
    end

endmodule

// File: rtl/dma3d_cnt.sv
module dma3d_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] bcnt_i,
    input  logic [CW-1:0] ccnt_i,
    input  logic [CW-1:0] rld_i,
    input  logic          ab_mode_i,
    input  logic          issue_i,
    output logic          frame_end_o,
    output logic          blk_end_o
);

    logic [CW-1:0] b_left_q, c_left_q, bcnt_q, rld_q;
    logic          b_last, c_last;

    always_comb begin
        b_last      = (b_left_q == CW'(1));
        c_last      = (c_left_q == CW'(1));
        frame_end_o = issue_i && b_last;
        blk_end_o   = issue_i && b_last && c_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_left_q <= '0;
            c_left_q <= '0;
            bcnt_q   <= '0;
            rld_q    <= '0;
        end else if (load_i) begin
            b_left_q <= bcnt_i;
            c_left_q <= ccnt_i;
            bcnt_q   <= bcnt_i;
            rld_q    <= rld_i;
        end else if (issue_i) begin
            if (b_last) begin
                b_left_q <= ab_mode_i ? bcnt_q : rld_q;
                c_left_q <= c_left_q - CW'(1);
            end else begin
                b_left_q <= b_left_q - CW'(1);
            end
        end
    end

endmodule

// File: rtl/dma3d_agen.sv
module dma3d_agen #(
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] start_i,
    input  logic [IW-1:0] aidx_i,
    input  logic [IW-1:0] fidx_i,
    input  logic          fixed_i,
    input  logic          ab_mode_i,
    input  logic          issue_i,
    input  logic          frame_end_i,
    output logic [AW-1:0] addr_o
);

    localparam int EXT = AW - IW;

    logic [AW-1:0] cur_q, fst_q;
    logic [IW-1:0] aidx_q, fidx_q;
    logic          fixed_q;
    logic [AW-1:0] step_a, step_f;

    always_comb begin
        step_a = {{EXT{aidx_q[IW-1]}}, aidx_q};
        step_f = {{EXT{fidx_q[IW-1]}}, fidx_q};
        addr_o = cur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            fst_q   <= '0;
            aidx_q  <= '0;
            fidx_q  <= '0;
            fixed_q <= 1'b0;
        end else if (load_i) begin
            cur_q   <= start_i;
            fst_q   <= start_i;
            aidx_q  <= aidx_i;
            fidx_q  <= fidx_i;
            fixed_q <= fixed_i;
        end else if (issue_i && !fixed_q) begin
            if (!frame_end_i) begin
                cur_q <= cur_q + step_a;
            end else if (ab_mode_i) begin
                cur_q <= fst_q + step_f;
                fst_q <= fst_q + step_f;
            end else begin
                cur_q <= cur_q + step_f;
            end
        end
    end

endmodule

// File: rtl/dma3d_addr_seq.sv
module dma3d_addr_seq
    import dma3d_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int IW  = 16,
    parameter int FWW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            ab_mode_i,
    input  logic            src_fifo_i,
    input  logic            dst_fifo_i,
    input  logic [FWW-1:0]  fifo_width_i,
    input  logic [AW-1:0]   src_i,
    input  logic [AW-1:0]   dst_i,
    input  logic [2*CW-1:0] cnt_i,
    input  logic [CW-1:0]   ccnt_i,
    input  logic [2*IW-1:0] aidx_i,
    input  logic [2*IW-1:0] fidx_i,
    input  logic [CW-1:0]   rld_i,
    input  logic            sync_i,
    output logic            req_valid_o,
    output logic [AW-1:0]   req_src_o,
    output logic [AW-1:0]   req_dst_o,
    output logic [CW-1:0]   req_len_o,
    output logic [FWW-1:0]  fifo_width_o,
    output logic            done_o
);

    logic [CW-1:0]  acnt_q;
    logic [FWW-1:0] fw_q;
    logic           ab_q;
    logic           issue, frame_end, blk_end, unit_end;

    logic [NUM_SIDES-1:0][AW-1:0] side_start;
    logic [NUM_SIDES-1:0][IW-1:0] side_aidx;
    logic [NUM_SIDES-1:0][IW-1:0] side_fidx;
    logic [NUM_SIDES-1:0]         side_fixed;
    logic [NUM_SIDES-1:0][AW-1:0] side_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acnt_q <= '0;
            fw_q   <= '0;
            ab_q   <= 1'b0;
        end else if (load_i) begin
            acnt_q <= cnt_i[CW-1:0];
            fw_q   <= fifo_width_i;
            ab_q   <= ab_mode_i;
        end
    end

    always_comb begin
        unit_end = ab_q ? frame_end : issue;
    end

    dma3d_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .sync_i     (sync_i),
        .unit_end_i (unit_end),
        .blk_end_i  (blk_end),
        .issue_o    (issue)
    );

    dma3d_cnt #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .bcnt_i      (cnt_i[2*CW-1:CW]),
        .ccnt_i      (ccnt_i),
        .rld_i       (rld_i),
        .ab_mode_i   (ab_q),
        .issue_i     (issue),
        .frame_end_o (frame_end),
        .blk_end_o   (blk_end)
    );

    always_comb begin
        side_start[SIDE_SRC] = src_i;
        side_start[SIDE_DST] = dst_i;
        side_fixed[SIDE_SRC] = src_fifo_i;
        side_fixed[SIDE_DST] = dst_fifo_i;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        assign side_aidx[s] = aidx_i[s*IW +: IW];
        assign side_fidx[s] = fidx_i[s*IW +: IW];

        dma3d_agen #(.AW(AW), .IW(IW)) u_agen (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (load_i),
            .start_i     (side_start[s]),
            .aidx_i      (side_aidx[s]),
            .fidx_i      (side_fidx[s]),
            .fixed_i     (side_fixed[s]),
            .ab_mode_i   (ab_q),
            .issue_i     (issue),
            .frame_end_i (frame_end),
            .addr_o      (side_addr[s])
        );
    end

    always_comb begin
        req_valid_o  = issue;
        req_src_o    = side_addr[SIDE_SRC];
        req_dst_o    = side_addr[SIDE_DST];
        req_len_o    = acnt_q;
        fifo_width_o = fw_q;
        done_o       = blk_end;
    end

endmodule

// File: rtl/dma3d_chk.sv
module dma3d_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid_o,
    input logic [AW-1:0] req_src_o,
    input logic [CW-1:0] req_len_o,
    input logic          done_o,
    input logic          ab_q,
    input logic          src_fixed
);

    AST_DONE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_valid_o); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !req_valid_o); // R11

    AST_ONE_PER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !ab_q) |=> !req_valid_o); // R2

    AST_LEN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && $past(req_valid_o)) |-> $stable(req_len_o)); // R4

    AST_FIXED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && $past(req_valid_o) && src_fixed) |-> $stable(req_src_o)); // R9

endmodule

bind dma3d_addr_seq dma3d_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_o (req_valid_o),
    .req_src_o   (req_src_o),
    .req_len_o   (req_len_o),
    .done_o      (done_o),
    .ab_q        (ab_q),
    .src_fixed   (g_side[0].u_agen.fixed_q)
);

// File: tb/dma3d_addr_seq_tb_top.sv
module dma3d_addr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0, ab_mode_i = 1'b0, src_fifo_i = 1'b0, dst_fifo_i = 1'b0;
    logic [2:0]  fifo_width_i = '0;
    logic [31:0] src_i = '0, dst_i = '0, cnt_i = '0, aidx_i = '0, fidx_i = '0;
    logic [15:0] ccnt_i = '0, rld_i = '0;
    logic        sync_i = 1'b0;
    logic        req_valid_o, done_o;
    logic [31:0] req_src_o, req_dst_o;
    logic [15:0] req_len_o;
    logic [2:0]  fifo_width_o;

    always #5 clk = ~clk;

    dma3d_addr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .ab_mode_i(ab_mode_i),
        .src_fifo_i(src_fifo_i), .dst_fifo_i(dst_fifo_i), .fifo_width_i(fifo_width_i),
        .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i), .ccnt_i(ccnt_i),
        .aidx_i(aidx_i), .fidx_i(fidx_i), .rld_i(rld_i), .sync_i(sync_i),
        .req_valid_o(req_valid_o), .req_src_o(req_src_o), .req_dst_o(req_dst_o),
        .req_len_o(req_len_o), .fifo_width_o(fifo_width_o), .done_o(done_o)
    );

    int n_chk = 0, n_bad = 0, done_cnt = 0;
    logic [31:0] got_s[$], got_d[$], exp_s[$], exp_d[$];
    logic [15:0] got_l[$];

    // parameter set under test
    logic [31:0] p_src, p_dst;
    logic [15:0] p_a, p_b, p_c, p_rld, p_sa, p_da, p_sf, p_df;
    logic        p_ab, p_sc, p_dc;
    logic [2:0]  p_fw;

    always @(negedge clk) begin
        if (rst_n && req_valid_o) begin
            got_s.push_back(req_src_o);
            got_d.push_back(req_dst_o);
            got_l.push_back(req_len_o);
        end
        if (rst_n && done_o) done_cnt++;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // expected array list from the requirements
    function automatic void build_model();
        logic [31:0] s, d, fs, fd;
        int nb;
        exp_s.delete(); exp_d.delete();
        s = p_src; d = p_dst; fs = p_src; fd = p_dst; nb = int'(p_b);
        for (int f = 0; f < int'(p_c); f++) begin
            for (int i = 0; i < nb; i++) begin
                exp_s.push_back(s);
                exp_d.push_back(d);
                if (i < nb - 1) begin
                    if (!p_sc) s = s + sx(p_sa);
                    if (!p_dc) d = d + sx(p_da);
                end else if (p_ab) begin
                    if (!p_sc) begin fs = fs + sx(p_sf); s = fs; end
                    if (!p_dc) begin fd = fd + sx(p_df); d = fd; end
                end else begin
                    if (!p_sc) s = s + sx(p_sf);
                    if (!p_dc) d = d + sx(p_df);
                end
            end
            nb = p_ab ? int'(p_b) : int'(p_rld);
        end
    endfunction

    task automatic do_load();
        @(negedge clk);
        ab_mode_i = p_ab; src_fifo_i = p_sc; dst_fifo_i = p_dc; fifo_width_i = p_fw;
        src_i = p_src; dst_i = p_dst; cnt_i = {p_b, p_a}; ccnt_i = p_c;
        aidx_i = {p_da, p_sa}; fidx_i = {p_df, p_sf}; rld_i = p_rld;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        got_s.delete(); got_d.delete(); got_l.delete();
        check(fifo_width_o == p_fw, "R10 width code", 32'(fifo_width_o), 32'(p_fw));
    endtask

    task automatic sync_pulse();
        @(negedge clk); sync_i = 1'b1;
        @(negedge clk); sync_i = 1'b0;
    endtask

    task automatic run_block();
        int d0 = done_cnt;
        for (int k = 0; k < 40; k++) begin
            if (done_cnt != d0) break;
            sync_pulse();
            repeat (5) @(negedge clk);
        end
        check(done_cnt == d0 + 1, "R11 one done per block", 32'(done_cnt - d0), 32'd1);
    endtask

    task automatic compare_block(input string tag);
        build_model();
        check(got_s.size() == exp_s.size(), {tag, " R8 request count"}, 32'(got_s.size()), 32'(exp_s.size()));
        for (int i = 0; i < exp_s.size() && i < got_s.size(); i++) begin
            check(got_s[i] == exp_s[i], {tag, " R5 R6 R7 src"}, got_s[i], exp_s[i]);
            check(got_d[i] == exp_d[i], {tag, " R5 R6 R7 dst"}, got_d[i], exp_d[i]);
            check(got_l[i] == p_a, {tag, " R4 length"}, 32'(got_l[i]), 32'(p_a));
        end
    endtask

    task automatic set_params(input logic ab, input logic [15:0] b, input logic [15:0] c, input logic [15:0] rld);
        p_ab = ab; p_b = b; p_c = c; p_rld = rld;
        p_src = 32'h1000_0000; p_dst = 32'h2000_0000; p_a = 16'd8;
        p_sa = 16'd16; p_da = 16'hFFF0; p_sf = 16'h0100; p_df = 16'hFF00;
        p_sc = 1'b0; p_dc = 1'b0; p_fw = 3'd2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_valid_o == 1'b0, "R1 valid in reset", 32'(req_valid_o), 0);
        check(done_o == 1'b0, "R1 done in reset", 32'(done_o), 0);
        rst_n = 1'b1;
        sync_pulse();
        repeat (4) @(negedge clk);
        check(got_s.size() == 0, "R1 sync before load ignored", 32'(got_s.size()), 0);

        // R2 latency, R6 and R8 frame transition with reload
        set_params(1'b0, 16'd3, 16'd2, 16'd2);
        do_load();
        sync_i = 1'b1;
        @(negedge clk); sync_i = 1'b0;
        check(req_valid_o == 1'b1, "R2 request after event", 32'(req_valid_o), 1);
        @(negedge clk);
        check(req_valid_o == 1'b0, "R2 single array per event", 32'(req_valid_o), 0);
        run_block();
        compare_block("async");

        // R12 held event, R3 frame per event, R7
        set_params(1'b1, 16'd3, 16'd3, 16'd1);
        do_load();
        sync_pulse();
        sync_i = 1'b1; @(negedge clk); @(negedge clk); sync_i = 1'b0;
        repeat (10) @(negedge clk);
        check(got_s.size() == 6, "R12 one held event served", 32'(got_s.size()), 6);
        check(done_cnt == 1, "R3 no done mid-block", 32'(done_cnt), 1);
        sync_pulse();
        repeat (6) @(negedge clk);
        check(got_s.size() == 9, "R3 whole frame per event", 32'(got_s.size()), 9);
        check(done_cnt == 2, "R11 done at end", 32'(done_cnt), 2);
        compare_block("absync");
        // R11: events after done ignored
        sync_pulse(); sync_pulse();
        repeat (6) @(negedge clk);
        check(got_s.size() == 9, "R11 quiet after done", 32'(got_s.size()), 9);

        // R9 constant source side
        set_params(1'b1, 16'd4, 16'd2, 16'd1);
        p_sc = 1'b1; p_fw = 3'd5;
        do_load();
        run_block();
        compare_block("fifo");
        for (int i = 0; i < got_s.size(); i++)
            check(got_s[i] == p_src, "R9 constant source", got_s[i], p_src);

        // R13 reload mid-block
        set_params(1'b0, 16'd4, 16'd3, 16'd2);
        do_load();
        sync_pulse(); sync_pulse();
        set_params(1'b1, 16'd2, 16'd2, 16'd3);
        p_src = 32'h0000_4000; p_dst = 32'h0000_8000; p_sf = 16'hFFC0;
        do_load();
        run_block();
        compare_block("R13 restart");

        // random blocks
        for (int t = 0; t < 25; t++) begin
            p_ab = 1'($urandom); p_sc = ($urandom % 5) == 0; p_dc = ($urandom % 5) == 0;
            p_fw = 3'($urandom); p_src = $urandom; p_dst = $urandom;
            p_a = 16'($urandom % 64 + 1); p_b = 16'($urandom % 4 + 1);
            p_c = 16'($urandom % 4 + 1); p_rld = 16'($urandom % 4 + 1);
            p_sa = 16'($urandom); p_da = 16'($urandom); p_sf = 16'($urandom); p_df = 16'($urandom);
            do_load();
            run_block();
            compare_block("random");
        end
        finish_run();
    end

endmodule